// File: doc/BRIEF.md
# PWM Fault and Retrigger Input Conditioner

This block turns one asynchronous fault or retrigger signal into clean, clock-aligned action requests for a PWM generator. An 8-bit control word, loaded through a single write strobe, picks the event source (an external pin or an analog comparator output), the active polarity, an optional noise filter, a capture request and a 4-bit action mode. The chosen signal is synchronized, optionally filtered, polarity-adjusted, then split into an active level and an active edge.

The mode field turns those events into requests for the PWM core. Edge-driven modes send one-cycle pulses: stop and jump to the opposite dead-time, stop and run the opposite dead-time, stop and insert dead-time, or retrigger. Level-driven modes hold the opposite state, or blank the outputs, for as long as the fault stays active. The halt mode latches until software pulses a clear input. A capture pulse can be produced on every active edge, whatever the mode. The counter, dead-time logic and capture register live in the PWM core. The block has no data stream, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `pwm_fault_cond`

## Requirements
- R1: After reset the control word is zero and every output is low.
- R2: Control bit 6 selects the source. 0 takes `pin_in` and 1 takes `cmp_in`. The source that is not selected has no effect on any output.
- R3: Control bit 5 sets polarity. 0 makes the low level and the falling edge active. 1 makes the high level and the rising edge active.
- R4: With the filter off, a step on the selected input that is driven between clock edges shows up on the outputs just after the third rising clock edge. Edge requests last exactly one cycle.
- R5: Control bit 4 enables the filter. The conditioned level only changes after four consecutive samples agree. This adds four cycles of latency, so outputs appear after the seventh edge, and a pulse lasting three samples produces no output.
- R6: Mode 0000 and modes 1001 to 1111 produce no action request and no fault level.
- R7: On an active edge, modes 0001 and 0110 pulse `stop_jump_req`, mode 0010 pulses `stop_run_dt_req`, and mode 0101 pulses `stop_ins_dt_req`.
- R8: While the input is active, mode 0011 holds `opp_hold` high and mode 0100 holds `outputs_off` high. In both modes `fault_active` is high at the same time, and all three follow the input with the same latency.
- R9: In mode 0111 an active edge sets `halt_active`. It stays set until `halt_clr` is sampled high. If a new edge arrives in the same cycle as the clear, the set wins.
- R10: In mode 1000 an active edge pulses `retrig_req` for one cycle.
- R11: When control bit 7 is set, every active edge pulses `cap_pulse` for one cycle, in any mode. When the bit is clear, `cap_pulse` never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Loads `ctrl_wdata` into the control word |
| ctrl_wdata | input | 8 | Control word: [7] capture, [6] source, [5] polarity, [4] filter, [3:0] mode |
| pin_in | input | 1 | External fault/retrigger pin (asynchronous) |
| cmp_in | input | 1 | Comparator output (asynchronous) |
| halt_clr | input | 1 | Software clear for the halt latch |
| cap_pulse | output | 1 | One-cycle capture request |
| stop_jump_req | output | 1 | Stop, jump to opposite dead-time and wait |
| stop_run_dt_req | output | 1 | Stop, run opposite dead-time and wait |
| stop_ins_dt_req | output | 1 | Stop and insert dead-time |
| retrig_req | output | 1 | Retrigger the PWM cycle |
| opp_hold | output | 1 | Hold opposite state while fault is active |
| outputs_off | output | 1 | Deactivate PWM outputs, timing untouched |
| fault_active | output | 1 | A level-mode fault is present |
| halt_active | output | 1 | Generator halted, waiting for software |

## Verification
Every result is registered at the end of the chain. A step driven between edges therefore reaches the outputs after three rising edges with the filter off and seven with it on. Releasing a level fault takes the same number of edges. The halt clear acts on the next edge. The bench drives and samples on falling edges. It checks the cycle just before the due cycle (expecting silence), the due cycle (expecting the pulse and levels), and the cycle after it (expecting pulses gone and levels held). This pins every pulse to a single cycle.

// File: rtl/pfc_pkg.sv
`timescale 1ns/1ps
package pfc_pkg;

  localparam int CTRL_W = 8;

  // Control word layout; bit positions are part of the write port contract.
  typedef struct packed {
    logic       cap_en;    // [7]
    logic       src_cmp;   // [6]
    logic       pol_high;  // [5]
    logic       filt_en;   // [4]
    logic [3:0] mode;      // [3:0]
  } ctrl_t;

  typedef enum logic [3:0] {
    M_IGNORE      = 4'd0,
    M_STOP_JUMP   = 4'd1,
    M_STOP_RUN_DT = 4'd2,
    M_OPP_HOLD    = 4'd3,
    M_OUT_OFF     = 4'd4,
    M_STOP_INS_DT = 4'd5,
    M_STOP_JUMP_B = 4'd6,
    M_HALT        = 4'd7,
    M_RETRIG      = 4'd8
  } mode_e;

  typedef struct packed {
    logic stop_jump;
    logic stop_run_dt;
    logic stop_ins_dt;
    logic retrig;
    logic halt_set;
    logic opp_hold;
    logic outputs_off;
  } req_t;

endpackage

// File: rtl/pfc_sync.sv
`timescale 1ns/1ps
module pfc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pfc_filter.sv
`timescale 1ns/1ps
module pfc_filter #(
  parameter int TAPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  localparam int HIST_W = TAPS - 1;

  logic [HIST_W-1:0] hist;
  logic [TAPS-1:0]   window;
  logic              filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist[0] <= 1'b0;
    else        hist[0] <= d;
  end

  for (genvar i = 1; i < HIST_W; i++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist[i] <= 1'b0;
      else        hist[i] <= hist[i-1];
    end
  end

  assign window = {hist, d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           filt_q <= 1'b0;
    else if (&window)     filt_q <= 1'b1;
    else if (~|window)    filt_q <= 1'b0;
  end

  assign q = en ? filt_q : d;
endmodule

// File: rtl/pfc_event.sv
`timescale 1ns/1ps
module pfc_event (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic pol_high,
  output logic act_lvl,
  output logic act_edge
);
  logic act_prev;

  assign act_lvl = pol_high ? lvl : ~lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_prev <= 1'b0;
    else        act_prev <= act_lvl;
  end

  assign act_edge = act_lvl & ~act_prev;
endmodule

// File: rtl/pfc_decode.sv
`timescale 1ns/1ps
module pfc_decode
  import pfc_pkg::*;
(
  input  logic [3:0] mode,
  input  logic       act_lvl,
  input  logic       act_edge,
  output req_t       req
);
  always_comb begin
    req = '0;
    case (mode)
      M_STOP_JUMP,
      M_STOP_JUMP_B: req.stop_jump   = act_edge;
      M_STOP_RUN_DT: req.stop_run_dt = act_edge;
      M_STOP_INS_DT: req.stop_ins_dt = act_edge;
      M_RETRIG:      req.retrig      = act_edge;
      M_HALT:        req.halt_set    = act_edge;
      M_OPP_HOLD:    req.opp_hold    = act_lvl;
      M_OUT_OFF:     req.outputs_off = act_lvl;
      default:       req = '0;
    endcase
  end
endmodule

// File: rtl/pwm_fault_cond.sv
`timescale 1ns/1ps
module pwm_fault_cond
  import pfc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              pin_in,
  input  logic              cmp_in,
  input  logic              halt_clr,
  output logic              cap_pulse,
  output logic              stop_jump_req,
  output logic              stop_run_dt_req,
  output logic              stop_ins_dt_req,
  output logic              retrig_req,
  output logic              opp_hold,
  output logic              outputs_off,
  output logic              fault_active,
  output logic              halt_active
);
  ctrl_t ctrl_q;
  logic  src_raw;
  logic  sync_lvl;
  logic  cond_lvl;
  logic  act_lvl;
  logic  act_edge;
  req_t  req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
  end

  assign src_raw = ctrl_q.src_cmp ? cmp_in : pin_in;

  pfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_raw), .q(sync_lvl)
  );

  pfc_filter #(.TAPS(FILT_TAPS)) u_filt (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.filt_en), .d(sync_lvl), .q(cond_lvl)
  );

  pfc_event u_evt (
    .clk(clk), .rst_n(rst_n), .lvl(cond_lvl), .pol_high(ctrl_q.pol_high),
    .act_lvl(act_lvl), .act_edge(act_edge)
  );

  pfc_decode u_dec (
    .mode(ctrl_q.mode), .act_lvl(act_lvl), .act_edge(act_edge), .req(req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_pulse       <= 1'b0;
      stop_jump_req   <= 1'b0;
      stop_run_dt_req <= 1'b0;
      stop_ins_dt_req <= 1'b0;
      retrig_req      <= 1'b0;
      opp_hold        <= 1'b0;
      outputs_off     <= 1'b0;
      fault_active    <= 1'b0;
      halt_active     <= 1'b0;
    end else begin
      cap_pulse       <= ctrl_q.cap_en & act_edge;
      stop_jump_req   <= req.stop_jump;
      stop_run_dt_req <= req.stop_run_dt;
      stop_ins_dt_req <= req.stop_ins_dt;
      retrig_req      <= req.retrig;
      opp_hold        <= req.opp_hold;
      outputs_off     <= req.outputs_off;
      fault_active    <= req.opp_hold | req.outputs_off;
      if (req.halt_set)  halt_active <= 1'b1;
      else if (halt_clr) halt_active <= 1'b0;
    end
  end
endmodule

// File: rtl/pfc_checker.sv
`timescale 1ns/1ps
module pfc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode,
  input logic       cap_en,
  input logic       halt_clr,
  input logic       cap_pulse,
  input logic       stop_jump_req,
  input logic       stop_run_dt_req,
  input logic       stop_ins_dt_req,
  input logic       retrig_req,
  input logic       fault_active,
  input logic       halt_active
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stop_jump_req, stop_run_dt_req, stop_ins_dt_req, retrig_req})); // R7
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_jump_req |=> !stop_jump_req); // R4
  AST_IDLE_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0 || mode > 4'd8) |=>
      !(stop_jump_req || stop_run_dt_req || stop_ins_dt_req || retrig_req || fault_active)); // R6
  AST_LEVEL_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode == 4'd3 || mode == 4'd4) |=> !fault_active); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_active && !halt_clr) |=> halt_active); // R9
  AST_RETRIG_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 4'd8) |=> !retrig_req); // R10
  AST_CAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> !cap_pulse); // R11
  AST_CAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> !cap_pulse); // R11
endmodule

bind pwm_fault_cond pfc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .cap_en(ctrl_q.cap_en),
  .halt_clr(halt_clr), .cap_pulse(cap_pulse), .stop_jump_req(stop_jump_req),
  .stop_run_dt_req(stop_run_dt_req), .stop_ins_dt_req(stop_ins_dt_req),
  .retrig_req(retrig_req), .fault_active(fault_active), .halt_active(halt_active)
);

// File: tb/pwm_fault_cond_tb.sv
`timescale 1ns/1ps
module pwm_fault_cond_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       pin_in = 1'b0;
  logic       cmp_in = 1'b0;
  logic       halt_clr = 1'b0;
  logic       cap_pulse, stop_jump_req, stop_run_dt_req, stop_ins_dt_req, retrig_req;
  logic       opp_hold, outputs_off, fault_active, halt_active;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pwm_fault_cond u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .pin_in(pin_in), .cmp_in(cmp_in), .halt_clr(halt_clr),
    .cap_pulse(cap_pulse), .stop_jump_req(stop_jump_req),
    .stop_run_dt_req(stop_run_dt_req), .stop_ins_dt_req(stop_ins_dt_req),
    .retrig_req(retrig_req), .opp_hold(opp_hold), .outputs_off(outputs_off),
    .fault_active(fault_active), .halt_active(halt_active)
  );

  // [8]cap [7]stop_jump [6]stop_run_dt [5]stop_ins_dt [4]retrig
  // [3]opp_hold [2]outputs_off [1]fault_active [0]halt_active
  function automatic logic [8:0] obs();
    return {cap_pulse, stop_jump_req, stop_run_dt_req, stop_ins_dt_req, retrig_req,
            opp_hold, outputs_off, fault_active, halt_active};
  endfunction

  function automatic logic [8:0] exp_hit(input logic [7:0] c);
    logic [8:0] v = '0;
    v[8] = c[7];
    case (c[3:0])
      4'd1, 4'd6: v[7] = 1'b1;
      4'd2:       v[6] = 1'b1;
      4'd5:       v[5] = 1'b1;
      4'd8:       v[4] = 1'b1;
      4'd3:       begin v[3] = 1'b1; v[1] = 1'b1; end
      4'd4:       begin v[2] = 1'b1; v[1] = 1'b1; end
      4'd7:       v[0] = 1'b1;
      default:    ;
    endcase
    return v;
  endfunction

  function automatic string mode_tag(input logic [7:0] c);
    string s;
    case (c[3:0])
      4'd1, 4'd2, 4'd5, 4'd6: s = "R7";
      4'd3, 4'd4:             s = "R8";
      4'd7:                   s = "R9";
      4'd8:                   s = "R10";
      default:                s = "R6";
    endcase
    if (c[7]) s = {s, " R11"};
    s = {s, c[4] ? " R5" : " R4", " R3"};
    if (c[6]) s = {s, " R2"};
    return s;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] c);
    ctrl_we = 1'b1; ctrl_wdata = c;
    step(1);
    ctrl_we = 1'b0;
  endtask

  task automatic setup(input logic [7:0] c);
    pin_in = ~c[5]; cmp_in = ~c[5];
    step(12);
    write_ctrl(c);
    step(12);
    halt_clr = 1'b1; step(1); halt_clr = 1'b0;
    step(3);
  endtask

  task automatic trial(input logic [7:0] c);
    string tag = mode_tag(c);
    int    lat = c[4] ? 7 : 3;
    logic  inact = ~c[5];
    setup(c);
    check(tag, "idle", obs(), 9'h000);
    if (c[6]) cmp_in = ~inact; else pin_in = ~inact;
    step(lat - 1);
    check(tag, "before due", obs(), 9'h000);
    step(1);
    check(tag, "due", obs(), exp_hit(c));
    step(1);
    check(tag, "after due", obs(), exp_hit(c) & 9'h00F);
    pin_in = inact; cmp_in = inact;
    step(lat + 1);
    check(tag, "released", obs(), (c[3:0] == 4'd7) ? 9'h001 : 9'h000);
  endtask

  initial begin
    logic [8:0] acc;
    void'($urandom(32'd5150));
    step(3);
    rst_n = 1'b1;
    step(2);
    check("R1", "reset state", obs(), 9'h000);

    // R2: unselected comparator must not act; selected pin must.
    setup(8'h28);
    cmp_in = 1'b1;
    acc = '0;
    for (int i = 0; i < 8; i++) begin step(1); acc |= obs(); end
    check("R2", "unselected source", acc, 9'h000);
    cmp_in = 1'b0;
    step(4);
    pin_in = 1'b1;
    step(3);
    check("R2", "selected source", obs(), 9'h010);
    pin_in = 1'b0;
    step(6);

    // R5: a three-sample glitch is rejected by the filter.
    setup(8'h38);
    pin_in = 1'b1; step(3); pin_in = 1'b0;
    acc = '0;
    for (int i = 0; i < 14; i++) begin step(1); acc |= obs(); end
    check("R5", "glitch rejected", acc, 9'h000);

    // R3: active-low polarity with stop-jump.
    trial(8'h01);
    trial(8'h21);

    // R9: halt clears only on halt_clr.
    trial(8'h27);
    step(5);
    check("R9", "halt held", obs(), 9'h001);
    halt_clr = 1'b1; step(1); halt_clr = 1'b0;
    check("R9", "halt cleared", obs(), 9'h000);

    // Every mode code, capture and polarity varied.
    for (int m = 0; m < 16; m++) begin
      logic [3:0] mm = 4'(m);
      trial({mm[0], mm[2], mm[1], mm[3], mm});
    end

    // Constrained random control words.
    for (int k = 0; k < 40; k++) begin
      logic [7:0] c = 8'($urandom());
      if ($urandom_range(0, 3) == 0) c[3:0] = 4'($urandom_range(9, 15));
      trial(c);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule